// File: doc/BRIEF.md
# SPI Receive-Match and Mode-Fault Status Unit

This block keeps the receive-side and fault status of an SPI peripheral and serves them over a small register bus. Read and write strobes, an address and a data word make up the bus. Received bytes arrive on a valid/ready stream from the serial shifter. They land in a one-byte receive buffer. Each captured byte is compared with a programmable match value, and an equal value raises a match flag. A two-flop synchronizer brings in the active-low slave-select input. When the unit is configured as a master that watches slave-select, a low level on that input means that another master is driving the bus. This raises a mode-fault flag.

The receive stream uses back-pressure. `rx_ready` is high only while the buffer is empty. A byte is taken on a cycle where `rx_valid` and `rx_ready` are both high. The producer must hold the byte while `rx_ready` is low. Reading the data register empties the buffer and raises `rx_ready` again.

Both flags are sticky. Software clears a flag in two steps. First it reads the status while the flag is set. Then it makes a specific write. Register map: address 0 is the control register, address 1 is the status register, address 2 is the match value and address 3 is the receive data.

Top module: `spi_flag_unit`

## Requirements
- R1: `rx_ready` is 1 exactly while the receive buffer is empty. A byte accepted on a handshake sets status bit 7 (receive-full). Reading address 3 returns that byte and clears bit 7. A byte offered while the buffer is full is not taken.
- R2: Status bit 6 (match) sets one cycle after a byte is captured whose value equals the match register at address 2. It never sets for a differing byte, and it sets only while receive-full is 1.
- R3: The match flag clears only when both steps occur in order. First, a status read sees bit 6 at 1 and arms the clear. Second, a later status write has bit 6 at 1. A status write with bit 6 at 0 has no effect on the flag. Any status write uses up the armed state.
- R4: The control register at address 0 holds master (bit 0), fault-enable (bit 1) and select-output-enable (bit 2). With master=1, fault-enable=1 and select-output-enable=0, a low `ss_n` sets status bit 4 (mode fault) by the third rising edge after it is applied.
- R5: In every other combination of those three control bits, the mode-fault flag never sets.
- R6: The mode-fault flag clears only when both steps occur in order. First, a status read sees bit 4 at 1. Second, a later write to the control register follows. A control write with no such read leaves the flag at 1.
- R7: Status bits 5 and 3..0 always read 0. The control and match registers read back the value last written.
- R8: If a set condition and a clearing write meet in the same cycle, the flag stays set.
- R9: After reset, all flags, the control register and the match register read 0, and `rx_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid while `bus_rd` is high, 0 otherwise |
| rx_valid | input | 1 | Received byte is offered |
| rx_ready | output | 1 | Receive buffer can take a byte |
| rx_data | input | DATA_W | Received byte |
| ss_n | input | 1 | Asynchronous active-low slave-select input |

## Verification
On every cycle, the assertions check several things. An accepted byte fills the buffer, and the buffer holds still while full. Each flag rises only under its own set condition: a captured byte while receive-full is 1 for match, and the enabling mode with synchronized select low for mode fault. Each flag falls only after an armed clearing write. A set condition always leaves the flag at 1 on the next edge. Reserved status bits read 0.

Some behaviours appear only in the bench's sequences. These are that a write with bit 6 at 0 uses up the armed state, that the three-edge synchronizer latency holds, and that a byte offered while the buffer is full is really dropped. The readback values of the full register map are also shown only by these sequences.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;

  // status bit positions decoded by software
  localparam int unsigned STAT_FULL_BIT  = 7;
  localparam int unsigned STAT_MATCH_BIT = 6;
  localparam int unsigned STAT_FAULT_BIT = 4;
  localparam int unsigned STAT_W         = 8;

  // control register bit positions
  localparam int unsigned CTL_MASTER_BIT = 0;
  localparam int unsigned CTL_FEN_BIT    = 1;
  localparam int unsigned CTL_SSOE_BIT   = 2;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_STATUS = 2'd1,
    REG_MATCH  = 2'd2,
    REG_DATA   = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic ss_out_en;
    logic fault_en;
    logic master;
  } mode_t;

endpackage

// File: rtl/spi_ss_sync.sv
module spi_ss_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ss_n_async,
  output logic ss_n_sync
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b1;
          else        chain_q[s] <= ss_n_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b1;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign ss_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/spi_rx_match.sv
module spi_rx_match #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              data_rd,
  input  logic [DATA_W-1:0] match_val,
  input  logic              stat_rd,
  input  logic              stat_wr,
  input  logic              stat_wr_match,
  output logic [DATA_W-1:0] rx_buf,
  output logic              full_flag,
  output logic              match_flag
);

  logic              full_q;
  logic              cap_d_q;
  logic              arm_q;
  logic              match_q;
  logic [DATA_W-1:0] buf_q;
  logic              cap;
  logic              match_set;
  logic              match_clr;

  assign rx_ready  = !full_q;
  assign cap       = rx_valid && rx_ready;
  assign match_set = cap_d_q && (buf_q == match_val);
  assign match_clr = stat_wr && stat_wr_match && arm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q  <= 1'b0;
      cap_d_q <= 1'b0;
      buf_q   <= '0;
    end else begin
      cap_d_q <= cap;
      if (cap)          buf_q  <= rx_data;
      if (cap)          full_q <= 1'b1;
      else if (data_rd) full_q <= 1'b0;
    end
  end

  // clear handshake: a status read seeing the flag arms, any status write consumes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   arm_q <= 1'b0;
    else if (stat_wr)             arm_q <= 1'b0;
    else if (stat_rd && match_q)  arm_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         match_q <= 1'b0;
    else if (match_set) match_q <= 1'b1;
    else if (match_clr) match_q <= 1'b0;
  end

  assign rx_buf     = buf_q;
  assign full_flag  = full_q;
  assign match_flag = match_q;

  a_r1_accept_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready) |=> full_q);

  a_r1_hold_while_full: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |=> $stable(buf_q));

  a_r2_match_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match_q) |-> $past(full_q));

  a_r3_match_clear_armed: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(match_q) |-> $past(stat_wr && stat_wr_match && arm_q));

  a_r8_match_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    match_set |=> match_q);

endmodule

// File: rtl/spi_mode_fault.sv
module spi_mode_fault
  import spi_flag_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  mode_t mode,
  input  logic  ss_n_sync,
  input  logic  stat_rd,
  input  logic  ctrl_wr,
  output logic  fault_flag
);

  logic fault_q;
  logic arm_q;
  logic watch_en;
  logic fault_set;
  logic fault_clr;

  assign watch_en  = mode.master && mode.fault_en && !mode.ss_out_en;
  assign fault_set = watch_en && !ss_n_sync;
  assign fault_clr = ctrl_wr && arm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  arm_q <= 1'b0;
    else if (ctrl_wr)            arm_q <= 1'b0;
    else if (stat_rd && fault_q) arm_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         fault_q <= 1'b0;
    else if (fault_set) fault_q <= 1'b1;
    else if (fault_clr) fault_q <= 1'b0;
  end

  assign fault_flag = fault_q;

  a_r5_fault_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_q) |-> $past(mode.master && mode.fault_en && !mode.ss_out_en && !ss_n_sync));

  a_r6_fault_clear_armed: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_q) |-> $past(ctrl_wr && arm_q));

  a_r8_fault_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    fault_set |=> fault_q);

endmodule

// File: rtl/spi_flag_unit.sv
module spi_flag_unit
  import spi_flag_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              ss_n
);

  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(REG_CTRL);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(REG_STATUS);
  localparam logic [ADDR_W-1:0] A_MATCH  = ADDR_W'(REG_MATCH);
  localparam logic [ADDR_W-1:0] A_DATA   = ADDR_W'(REG_DATA);

  mode_t             ctrl_q;
  logic [DATA_W-1:0] match_q;
  logic [DATA_W-1:0] rx_buf;
  logic              full_flag;
  logic              match_flag;
  logic              fault_flag;
  logic              ss_n_sync;
  logic [STAT_W-1:0] status;

  logic ctrl_wr, stat_wr, match_wr, stat_rd, data_rd;

  assign ctrl_wr  = bus_wr && (bus_addr == A_CTRL);
  assign stat_wr  = bus_wr && (bus_addr == A_STATUS);
  assign match_wr = bus_wr && (bus_addr == A_MATCH);
  assign stat_rd  = bus_rd && (bus_addr == A_STATUS);
  assign data_rd  = bus_rd && (bus_addr == A_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      match_q <= '0;
    end else begin
      if (ctrl_wr) begin
        ctrl_q.master    <= bus_wdata[CTL_MASTER_BIT];
        ctrl_q.fault_en  <= bus_wdata[CTL_FEN_BIT];
        ctrl_q.ss_out_en <= bus_wdata[CTL_SSOE_BIT];
      end
      if (match_wr) match_q <= bus_wdata;
    end
  end

  spi_ss_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .ss_n_async (ss_n),
    .ss_n_sync  (ss_n_sync)
  );

  spi_rx_match #(.DATA_W(DATA_W)) u_rx (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_valid      (rx_valid),
    .rx_ready      (rx_ready),
    .rx_data       (rx_data),
    .data_rd       (data_rd),
    .match_val     (match_q),
    .stat_rd       (stat_rd),
    .stat_wr       (stat_wr),
    .stat_wr_match (bus_wdata[STAT_MATCH_BIT]),
    .rx_buf        (rx_buf),
    .full_flag     (full_flag),
    .match_flag    (match_flag)
  );

  spi_mode_fault u_fault (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (ctrl_q),
    .ss_n_sync  (ss_n_sync),
    .stat_rd    (stat_rd),
    .ctrl_wr    (ctrl_wr),
    .fault_flag (fault_flag)
  );

  always_comb begin
    status                 = '0;
    status[STAT_FULL_BIT]  = full_flag;
    status[STAT_MATCH_BIT] = match_flag;
    status[STAT_FAULT_BIT] = fault_flag;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (bus_addr == A_CTRL) begin
        bus_rdata[CTL_MASTER_BIT] = ctrl_q.master;
        bus_rdata[CTL_FEN_BIT]    = ctrl_q.fault_en;
        bus_rdata[CTL_SSOE_BIT]   = ctrl_q.ss_out_en;
      end else if (bus_addr == A_STATUS) begin
        bus_rdata[STAT_W-1:0] = status;
      end else if (bus_addr == A_MATCH) begin
        bus_rdata = match_q;
      end else if (bus_addr == A_DATA) begin
        bus_rdata = rx_buf;
      end
    end
  end

  a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_STATUS) |-> (bus_rdata[5] == 1'b0 && bus_rdata[3:0] == 4'd0));

  a_r7_idle_bus_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_rdata == '0));

endmodule

// File: tb/spi_flag_unit_tb.sv
`timescale 1ns/1ps
module spi_flag_unit_tb_top;

  localparam int unsigned DW = 8;
  localparam int unsigned AW = 2;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_RX = 2'd2;
  localparam logic [1:0] A_CTL = 2'd0, A_ST = 2'd1, A_MT = 2'd2, A_DT = 2'd3;

  // {req[3:0], op[1:0], addr[1:0], data[7:0], exp[7:0]}
  localparam int NV = 15;
  localparam logic [23:0] VEC [NV] = '{
    {4'd7, OP_WR, A_MT, 8'h5A, 8'h00},
    {4'd7, OP_RD, A_MT, 8'h00, 8'h5A},
    {4'd1, OP_RX, A_DT, 8'h33, 8'h00},
    {4'd2, OP_RD, A_ST, 8'h00, 8'h80},
    {4'd1, OP_RD, A_DT, 8'h00, 8'h33},
    {4'd1, OP_RD, A_ST, 8'h00, 8'h00},
    {4'd2, OP_RX, A_DT, 8'h5A, 8'h00},
    {4'd2, OP_RD, A_ST, 8'h00, 8'hC0},
    {4'd1, OP_RD, A_DT, 8'h00, 8'h5A},
    {4'd2, OP_RD, A_ST, 8'h00, 8'h40},
    {4'd3, OP_WR, A_ST, 8'h00, 8'h00},
    {4'd3, OP_WR, A_ST, 8'h40, 8'h00},
    {4'd3, OP_RD, A_ST, 8'h00, 8'h40},
    {4'd3, OP_WR, A_ST, 8'h40, 8'h00},
    {4'd3, OP_RD, A_ST, 8'h00, 8'h00}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_rd = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          rx_valid = 1'b0;
  logic          rx_ready;
  logic [DW-1:0] rx_data = '0;
  logic          ss_n = 1'b1;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  spi_flag_unit #(.DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .ss_n(ss_n)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 check(tag, bus_rdata, exp);
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic rx_push(input logic [7:0] d);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d;
    @(posedge clk); #1;
    rx_valid = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic set_ss(input logic v);
    @(negedge clk);
    ss_n = v;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R9: reset state
    bus_read(A_ST, 8'h00, "R9 status");
    bus_read(A_CTL, 8'h00, "R9 ctrl");
    bus_read(A_MT, 8'h00, "R9 match");
    #1 check("R9 rx_ready", {7'd0, rx_ready}, 8'h01);

    // vector table: R1, R2, R3, R7
    for (int i = 0; i < NV; i++) begin
      logic [23:0] v;
      v = VEC[i];
      case (v[19:18])
        OP_WR:   bus_write(v[17:16], v[15:8]);
        OP_RD:   bus_read(v[17:16], v[7:0], $sformatf("R%0d vec%0d", v[23:20], i));
        default: rx_push(v[15:8]);
      endcase
    end

    // R1: back-pressure while full
    rx_push(8'h77);
    check("R1 ready low when full", {7'd0, rx_ready}, 8'h00);
    rx_push(8'h11);
    bus_read(A_DT, 8'h77, "R1 byte offered while full dropped");
    check("R1 ready after read", {7'd0, rx_ready}, 8'h01);
    bus_read(A_ST, 8'h00, "R2 no match for differing byte");

    // R7: control readback
    bus_write(A_CTL, 8'h07);
    bus_read(A_CTL, 8'h07, "R7 ctrl readback");

    // R5: non-watching modes never fault
    set_ss(1'b0);
    bus_read(A_ST, 8'h00, "R5 ss output enabled");
    bus_write(A_CTL, 8'h01);
    repeat (3) @(posedge clk);
    bus_read(A_ST, 8'h00, "R5 fault disabled");
    bus_write(A_CTL, 8'h06);
    repeat (3) @(posedge clk);
    bus_read(A_ST, 8'h00, "R5 not master");

    // R4: watching mode faults on low select
    bus_write(A_CTL, 8'h03);
    repeat (2) @(posedge clk);
    bus_read(A_ST, 8'h10, "R4 fault set");

    // R8: clearing write collides with live set condition (read above armed)
    bus_write(A_CTL, 8'h03);
    bus_read(A_ST, 8'h10, "R8 set wins over clear");

    // R6: armed clear after select releases
    set_ss(1'b1);
    bus_write(A_CTL, 8'h03);
    bus_read(A_ST, 8'h00, "R6 armed ctrl write clears");

    // R6: unarmed ctrl write leaves flag set
    set_ss(1'b0);
    set_ss(1'b1);
    bus_write(A_CTL, 8'h03);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = A_ST;
    #1 check("R6 unarmed write keeps fault", bus_rdata, 8'h10);
    @(posedge clk); #1 bus_rd = 1'b0;
    bus_write(A_CTL, 8'h03);
    bus_read(A_ST, 8'h00, "R6 clear after read");

    // R4: synchronizer latency, not visible after two edges
    @(negedge clk);
    ss_n = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    bus_rd = 1'b1; bus_addr = A_ST;
    #1 check("R4 not yet after two edges", bus_rdata, 8'h00);
    @(posedge clk); #1;
    check("R4 visible by third edge", bus_rdata, 8'h10);
    bus_rd = 1'b0;

    summary();
    $finish;
  end

endmodule